// File: doc/BRIEF.md
# External Interrupt Request Prioritiser

This unit takes six active-low external interrupt pins and turns them into one prioritised request for the processor. Each pin is resynchronised to the core clock. The pin then feeds one bit of a request register, and a per-pin sense-mode bit decides how that bit behaves. In level sense the bit follows the pin. In edge sense the bit captures a falling transition and holds it until software clears it.

Every pin has a 4-bit priority. Priority 0 masks the pin. The arbiter looks at all pending, unmasked requests and reports the highest priority together with the number of the pin that wins it. When two pins have the same priority, the lower pin number wins.

Software reaches the request register, the sense-mode register and two priority registers through a small synchronous write port with a combinational read port. To clear edge-sensed requests, software reads the request register and then writes 0 only to the bits it saw set, writing 1 to all other bits.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, every pin is in level sense with priority 0, the request register reads 0, and `pendValid` is 0.
- R2: The pins are active low and pass through a two-flop synchroniser. A pin driven low before clock edge k shows in the request register after edge k+2 and not before.
- R3: In level sense (mode bit 0), a request bit is 1 exactly while its synchronised pin is low. Writes to the request register do not change it.
- R4: In edge sense (mode bit 1), a falling transition of the synchronised pin sets the request bit. The bit stays set after the pin returns high.
- R5: In edge sense, writing 0 to a request bit clears it, and writing 1 to it leaves its value unchanged.
- R6: In edge sense, when a falling transition and a clearing write land in the same cycle, the bit ends up set.
- R7: Priority fields are 4 bits wide. Address 2 holds pin k in bits [4k+3:4k] for k = 0..3. Address 3 holds pin 4 in bits [3:0] and pin 5 in bits [7:4]. Its bits [15:8] read as 0.
- R8: A pending request whose priority is 0 is never reported. With no unmasked request pending, `pendValid` is 0.
- R9: When unmasked requests are pending, `pendLevel` equals the highest pending priority and `pendIndex` names the pin that holds it.
- R10: When the highest pending priority is shared by several pins, `pendIndex` names the lowest-numbered of them.
- R11: Address 0 is the request register and address 1 the sense-mode register (bit i = 1 selects edge sense for pin i). Both sit in bits [5:0], and bits [15:6] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 6 | External request pins, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 request, 1 mode, 2-3 priority) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` (combinational) |
| pendValid | output | 1 | An unmasked request is pending |
| pendLevel | output | 4 | Priority of the winning request |
| pendIndex | output | 3 | Pin number of the winning request |

## Verification
In level sense the bench holds single pins and pairs of pins low and then releases them. This shows that the bits track the pins, that writes leave them untouched, and that the synchroniser latency is exactly two edges. In edge sense a short low pulse followed by release separates latching from tracking. An all-ones write followed by a targeted zero write separates the two outcomes of a clearing write. A falling edge timed into the same cycle as a clearing write shows which of the two wins. For arbitration, the bench uses pin sets with distinct priorities, equal priorities and a priority-0 pin. These tell the winner choice, the tie order and masking apart.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int PRIO_SEL_W = 4;

  typedef struct packed {
    logic                  wrReq;
    logic                  wrMode;
    logic                  wrPrio;
    logic [PRIO_SEL_W-1:0] prioSel;
  } regStrobe_t;
endpackage

// File: rtl/irqu_ctrl.sv
module irqu_ctrl
  import irqu_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] REQ_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PRIO_BASE = ADDR_W'(2);

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      if (regAddr == REQ_ADDR) begin
        strobe.wrReq = 1'b1;
      end else if (regAddr == MODE_ADDR) begin
        strobe.wrMode = 1'b1;
      end else begin
        strobe.wrPrio  = 1'b1;
        strobe.prioSel = PRIO_SEL_W'(regAddr - PRIO_BASE);
      end
    end
  end
endmodule

// File: rtl/irqu_datapath.sv
module irqu_datapath
  import irqu_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        irqPinN,
  input  regStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         regRdata,
  output logic [NUM_IRQ-1:0]        reqBits,
  output logic [NUM_IRQ*PRIO_W-1:0] prioFlat
);
  localparam int FIELDS    = DATA_W / PRIO_W;
  localparam int PRIO_BASE = 2;

  logic [NUM_IRQ-1:0] syncA, syncB, syncPrev, edgeMode, reqReg;
  logic [NUM_IRQ-1:0] fallSeen, clrWrite;
  logic [PRIO_W-1:0]  prio [NUM_IRQ];

  // two-flop synchroniser plus previous-value flop, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '1;
      syncB    <= '1;
      syncPrev <= '1;
    end else begin
      syncA    <= irqPinN;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign fallSeen = syncPrev & ~syncB;
  assign clrWrite = strobe.wrReq ? ~regWdata[NUM_IRQ-1:0] : '0;

  // request register: level bits track the pin, edge bits latch until cleared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (!edgeMode[i])     reqReg[i] <= ~syncB[i];
        else if (fallSeen[i]) reqReg[i] <= 1'b1;
        else if (clrWrite[i]) reqReg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              edgeMode <= '0;
    else if (strobe.wrMode) edgeMode <= regWdata[NUM_IRQ-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IRQ; i++) prio[i] <= '0;
    end else if (strobe.wrPrio) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (strobe.prioSel == PRIO_SEL_W'(i / FIELDS))
          prio[i] <= regWdata[(i % FIELDS)*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(0)) begin
      regRdata[NUM_IRQ-1:0] = reqReg;
    end else if (regAddr == ADDR_W'(1)) begin
      regRdata[NUM_IRQ-1:0] = edgeMode;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (regAddr == ADDR_W'(PRIO_BASE + i / FIELDS))
          regRdata[(i % FIELDS)*PRIO_W +: PRIO_W] = prio[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) prioFlat[i*PRIO_W +: PRIO_W] = prio[i];
  end

  assign reqBits = reqReg;

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
      p_level_track_r3: assert property (@(posedge clk) disable iff (!rstN)
        !edgeMode[g] |=> reqReg[g] == !$past(syncB[g]));
      p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
        edgeMode[g] && fallSeen[g] |=> reqReg[g]);
      p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
        edgeMode[g] && reqReg[g] && !clrWrite[g] |=> reqReg[g]);
      p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
        edgeMode[g] && clrWrite[g] && !fallSeen[g] |=> !reqReg[g]);
      p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
        edgeMode[g] && clrWrite[g] && fallSeen[g] |=> reqReg[g]);
    end
  endgenerate
endmodule

// File: rtl/irqu_arbiter.sv
module irqu_arbiter #(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        reqBits,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  output logic                      pendValid,
  output logic [PRIO_W-1:0]         pendLevel,
  output logic [IDX_W-1:0]          pendIndex
);
  logic [PRIO_W-1:0] curLvl;

  // strict compare keeps the earliest index on ties; level 0 never beats start
  always_comb begin
    pendLevel = '0;
    pendIndex = '0;
    curLvl    = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      curLvl = prioFlat[i*PRIO_W +: PRIO_W];
      if (reqBits[i] && curLvl > pendLevel) begin
        pendLevel = curLvl;
        pendIndex = IDX_W'(i);
      end
    end
  end

  assign pendValid = pendLevel != '0;

  p_winner_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> reqBits[pendIndex] &&
                  prioFlat[pendIndex*PRIO_W +: PRIO_W] == pendLevel);
  p_idle_when_none_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqBits == '0 |-> !pendValid);
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irqu_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqPinN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               pendValid,
  output logic [PRIO_W-1:0]  pendLevel,
  output logic [IDX_W-1:0]   pendIndex
);
  regStrobe_t                strobe;
  logic [NUM_IRQ-1:0]        reqBits;
  logic [NUM_IRQ*PRIO_W-1:0] prioFlat;

  irqu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobe(strobe)
  );

  irqu_datapath #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .strobe(strobe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .reqBits(reqBits), .prioFlat(prioFlat)
  );

  irqu_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rstN(rstN), .reqBits(reqBits), .prioFlat(prioFlat),
    .pendValid(pendValid), .pendLevel(pendLevel), .pendIndex(pendIndex)
  );
endmodule

// File: tb/irq_prio_unit_tb.sv
module irq_prio_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  irqPinN = '1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        pendValid;
  logic [3:0]  pendLevel;
  logic [2:0]  pendIndex;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_unit u_dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pendValid(pendValid), .pendLevel(pendLevel), .pendIndex(pendIndex)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] addr, logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [1:0] addr, output logic [15:0] data);
    @(negedge clk);
    regAddr = addr;
    #1 data = regRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkPend(string tag, logic v, logic [3:0] lvl, logic [2:0] idx);
    #1;
    check({tag, " valid"}, 16'(pendValid), 16'(v));
    if (v) begin
      check({tag, " level"}, 16'(pendLevel), 16'(lvl));
      check({tag, " index"}, 16'(pendIndex), 16'(idx));
    end
  endtask

  task automatic testReset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), d);
      check("R1 reset register", d, 16'h0000);
    end
    checkPend("R1 reset pend", 1'b0, 4'd0, 3'd0);
  endtask

  task automatic testPrioLayout();
    logic [15:0] d;
    writeReg(2'd2, 16'h4321);
    writeReg(2'd3, 16'hFF65);
    readReg(2'd2, d); check("R7 prio reg low", d, 16'h4321);
    readReg(2'd3, d); check("R7 prio reg high unused bits", d, 16'h0065);
    writeReg(2'd1, 16'hFFC0);
    readReg(2'd1, d); check("R11 mode unused bits", d, 16'h0000);
  endtask

  task automatic testLatency();
    logic [15:0] d;
    regAddr = 2'd0;
    @(negedge clk); irqPinN[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    #1 check("R2 not yet after two edges", regRdata, 16'h0000);
    @(negedge clk);
    #1 check("R2 visible after third edge", regRdata, 16'h0004);
    readReg(2'd0, d);
    check("R11 request bits only in [5:0]", d & 16'hFFC0, 16'h0000);
  endtask

  task automatic testLevel();
    logic [15:0] d;
    writeReg(2'd0, 16'h0000);
    readReg(2'd0, d); check("R3 write 0 ignored in level", d, 16'h0004);
    writeReg(2'd0, 16'h003F);
    readReg(2'd0, d); check("R3 write 1 ignored in level", d, 16'h0004);
    checkPend("R9 single pin 2", 1'b1, 4'd3, 3'd2);
    irqPinN[2] = 1'b1;
    waitCyc(4);
    readReg(2'd0, d); check("R3 release clears in level", d, 16'h0000);
  endtask

  task automatic testArbitration();
    irqPinN = 6'b110101;           // pins 1,3 low: prio 2 and 4
    waitCyc(4);
    checkPend("R9 pins 1 and 3", 1'b1, 4'd4, 3'd3);
    irqPinN[5] = 1'b0;             // pin 5 prio 6
    waitCyc(4);
    checkPend("R9 pin 5 joins", 1'b1, 4'd6, 3'd5);
    irqPinN = '1;
    writeReg(2'd2, 16'h5555);
    writeReg(2'd3, 16'h0055);
    irqPinN = 6'b101011;           // pins 2,4 low, equal prio
    waitCyc(4);
    checkPend("R10 tie picks lower", 1'b1, 4'd5, 3'd2);
    irqPinN = '1;
    writeReg(2'd2, 16'h5505);      // pin 1 masked
    irqPinN[1] = 1'b0;
    waitCyc(4);
    checkPend("R8 masked pin not reported", 1'b0, 4'd0, 3'd0);
    irqPinN = '1;
    waitCyc(4);
  endtask

  task automatic testEdge();
    logic [15:0] d;
    writeReg(2'd1, 16'h003F);
    writeReg(2'd2, 16'h4321);
    irqPinN[0] = 1'b0;
    waitCyc(3);
    irqPinN[0] = 1'b1;
    waitCyc(4);
    readReg(2'd0, d); check("R4 edge latched after release", d, 16'h0001);
    checkPend("R4 pending after release", 1'b1, 4'd1, 3'd0);
    writeReg(2'd0, 16'h003F);
    readReg(2'd0, d); check("R5 write 1 keeps bit", d, 16'h0001);
    writeReg(2'd0, 16'h003E);
    readReg(2'd0, d); check("R5 write 0 clears bit", d, 16'h0000);
    // R6: fall reaches the latch at the third edge after the pin drops
    @(negedge clk); irqPinN[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); regWrEn = 1'b1; regAddr = 2'd0; regWdata = 16'h0000;
    @(negedge clk); regWrEn = 1'b0;
    readReg(2'd0, d); check("R6 edge beats clearing write", d, 16'h0002);
    irqPinN[1] = 1'b1;
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    testReset();
    testPrioLayout();
    testLatency();
    testLevel();
    testArbitration();
    testEdge();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule